// File: doc/BRIEF.md
# Memory Access Watch and Error Monitor

This block observes access requests to three memory regions: a general-purpose on-chip RAM (region 0), a data tightly coupled RAM (region 1) and an instruction tightly coupled RAM (region 2). For each region it flags two kinds of event. The first is an access that the address decoder reports as falling outside the space allocated to that region. The second is an access that hits a programmed watch location in the chosen direction. Events are recorded in a sticky status register. A combined interrupt line is raised for any recorded flag whose signalling is enabled.

Each region presents a one-cycle request with an address, a read/write flag and the decoder's unallocated indication. Software sets up the block through a single-cycle register port with write strobe, word select and write data. Readback is combinational from the word select. There are two enable masks. The first decides which events are recorded at all. The second decides which recorded flags reach the interrupt line. Each region has one watch register that holds an 8-byte-unit address and a direction bit.

Top module: `mem_watch_mon`

## Requirements
- R1: After reset the status output, the interrupt line and the readback of every register word (0 to 5) are all zero.
- R2: A request on region r (0, 1, 2) with the unallocated indication high sets status bit r, if status-enable bit r is set.
- R3: A request on region r sets status bit 3+r when address bits [AW-1:3] equal that region's watch unit and the request direction equals the watch direction bit (0 = read, 1 = write). All eight byte addresses of the unit match. The neighbouring unit, the opposite direction and requests on other regions do not set the bit.
- R4: An event whose status-enable bit is clear leaves its status bit at zero.
- R5: Writing word 0 clears every status bit written with 1 and leaves bits written with 0 unchanged.
- R6: When an event and a clear hit the same status bit in the same cycle, the bit ends set.
- R7: The interrupt line is the OR over all six bits of (status AND signal-enable), registered. It changes one cycle after the status or signal-enable change that causes it.
- R8: Register words are: 0 status, 1 status-enable, 2 signal-enable, 3/4/5 watch for regions 0/1/2. Status and enable words read back only bits [5:0]. A watch word holds the direction in bit 0 and the unit address in bits [AW-3:1], and reads zero above them.
- R9: A status bit stays set until it is cleared, even if its status-enable bit is later cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 3 | Per-region request strobe, one cycle per request |
| acc_write | input | 3 | Per-region direction, 1 = write |
| acc_unalloc | input | 3 | Per-region decoder indication that the address is unallocated |
| acc_addr | input | 3*AW | Per-region byte address, region r in bits [r*AW +: AW] |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word select |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Combinational readback of the selected word |
| status_o | output | 6 | Status flags: bits 2:0 errors, bits 5:3 watch hits |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bench uses the defaults AW = 16 and DW = 32, so the watch unit field is 13 bits wide. With this width the bench can program the topmost unit 0x1FFF and hit it at byte addresses 0xFFF8 to 0xFFFF. An all-ones write shows that a watch word keeps exactly bits [13:0] and each mask word keeps bits [5:0]. The same setup lets the bench drive an event and a clear together on one bit, drop an enable under a recorded flag, and measure the one-cycle interrupt delay against a signal-enable change and against a clear.

// File: rtl/mwm_pkg.sv
package mwm_pkg;
  localparam int NUM_REGION = 3;
  localparam int NUM_FLAG   = 2 * NUM_REGION;
  localparam int SEL_W      = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS  = 3'd0,
    SEL_STAT_EN = 3'd1,
    SEL_SIG_EN  = 3'd2,
    SEL_WATCH0  = 3'd3,
    SEL_WATCH1  = 3'd4,
    SEL_WATCH2  = 3'd5
  } reg_sel_e;

  function automatic int err_pos(input int region);
    return region;
  endfunction

  function automatic int hit_pos(input int region);
    return NUM_REGION + region;
  endfunction
endpackage

// File: rtl/mwm_watch_cmp.sv
module mwm_watch_cmp #(
  parameter int AW = 16,
  localparam int WW = AW - 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic          write_i,
  input  logic          unalloc_i,
  input  logic [AW-1:0] addr_i,
  input  logic [WW-1:0] unit_i,
  input  logic          dir_i,
  output logic          err_ev_o,
  output logic          hit_ev_o
);
  logic          unit_eq;
  logic          dir_eq;
  logic [2:0]    unused_offset;

  assign unused_offset = addr_i[2:0];

  always_comb begin
    unit_eq  = (addr_i[AW-1:3] == unit_i);
    dir_eq   = (write_i == dir_i);
    err_ev_o = valid_i && unalloc_i;
    hit_ev_o = valid_i && unit_eq && dir_eq;
  end

  // R3
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev_o |-> (valid_i && write_i == dir_i));

  // R2
  err_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_ev_o |-> (valid_i && unalloc_i));
endmodule

// File: rtl/mwm_cfg_regs.sv
module mwm_cfg_regs
  import mwm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int WW = AW - 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr_i,
  input  logic [SEL_W-1:0]         reg_addr_i,
  input  logic [DW-1:0]            reg_wdata_i,
  input  logic [NUM_FLAG-1:0]      status_i,
  output logic [NUM_FLAG-1:0]      stat_en_o,
  output logic [NUM_FLAG-1:0]      sig_en_o,
  output logic [NUM_REGION*WW-1:0] unit_o,
  output logic [NUM_REGION-1:0]    dir_o,
  output logic [NUM_FLAG-1:0]      clr_o,
  output logic [DW-1:0]            reg_rdata_o
);
  logic [NUM_FLAG-1:0] stat_en_q, stat_en_d;
  logic [NUM_FLAG-1:0] sig_en_q, sig_en_d;
  logic                stat_en_we, sig_en_we;
  logic [WW-1:0]       unit_q [NUM_REGION];
  logic                dir_q  [NUM_REGION];
  logic                unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DW-1:WW+1];

  always_comb begin
    stat_en_we = reg_wr_i && (reg_addr_i == SEL_STAT_EN);
    sig_en_we  = reg_wr_i && (reg_addr_i == SEL_SIG_EN);
    stat_en_d  = stat_en_we ? reg_wdata_i[NUM_FLAG-1:0] : stat_en_q;
    sig_en_d   = sig_en_we  ? reg_wdata_i[NUM_FLAG-1:0] : sig_en_q;
    clr_o      = (reg_wr_i && reg_addr_i == SEL_STATUS) ? reg_wdata_i[NUM_FLAG-1:0]
                                                        : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_en_q <= '0;
      sig_en_q  <= '0;
    end else begin
      if (stat_en_we) stat_en_q <= stat_en_d;
      if (sig_en_we)  sig_en_q  <= sig_en_d;
    end
  end

  for (genvar g = 0; g < NUM_REGION; g++) begin : g_watch
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(int'(SEL_WATCH0) + g);
    logic          we;
    logic [WW-1:0] unit_d;
    logic          dir_d;

    always_comb begin
      we     = reg_wr_i && (reg_addr_i == MY_SEL);
      unit_d = we ? reg_wdata_i[WW:1] : unit_q[g];
      dir_d  = we ? reg_wdata_i[0]    : dir_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        unit_q[g] <= '0;
        dir_q[g]  <= 1'b0;
      end else if (we) begin
        unit_q[g] <= unit_d;
        dir_q[g]  <= dir_d;
      end
    end

    assign unit_o[g*WW +: WW] = unit_q[g];
    assign dir_o[g]           = dir_q[g];

    // R8
    watch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == MY_SEL) |=>
        (unit_o[g*WW +: WW] == $past(reg_wdata_i[WW:1]) && dir_o[g] == $past(reg_wdata_i[0])));
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      SEL_STATUS:  reg_rdata_o[NUM_FLAG-1:0] = status_i;
      SEL_STAT_EN: reg_rdata_o[NUM_FLAG-1:0] = stat_en_q;
      SEL_SIG_EN:  reg_rdata_o[NUM_FLAG-1:0] = sig_en_q;
      default: begin
        for (int i = 0; i < NUM_REGION; i++) begin
          if (reg_addr_i == SEL_W'(int'(SEL_WATCH0) + i)) begin
            reg_rdata_o[WW:0] = {unit_q[i], dir_q[i]};
          end
        end
      end
    endcase
  end

  assign stat_en_o = stat_en_q;
  assign sig_en_o  = sig_en_q;

  // R8
  stat_en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_en_we |=> stat_en_o == $past(reg_wdata_i[NUM_FLAG-1:0]));

  // R8
  mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && (reg_addr_i == SEL_STAT_EN || reg_addr_i == SEL_SIG_EN)) |=>
      ($stable(stat_en_o) && $stable(sig_en_o)));
endmodule

// File: rtl/mwm_status_reg.sv
module mwm_status_reg
  import mwm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FLAG-1:0] ev_i,
  input  logic [NUM_FLAG-1:0] stat_en_i,
  input  logic [NUM_FLAG-1:0] sig_en_i,
  input  logic [NUM_FLAG-1:0] clr_i,
  output logic [NUM_FLAG-1:0] status_o,
  output logic                irq_o
);
  logic [NUM_FLAG-1:0] status_q, status_d;
  logic [NUM_FLAG-1:0] set_v;
  logic                irq_q, irq_d;

  always_comb begin
    set_v    = ev_i & stat_en_i;
    status_d = (status_q & ~clr_i) | set_v;
    irq_d    = |(status_q & sig_en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= irq_d;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  // R4
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(ev_i & stat_en_i)) == '0));

  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~$past(clr_i) & ~status_q) == '0));

  // R6
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_i & stat_en_i & clr_i) != '0) |=>
      ((status_q & $past(ev_i & stat_en_i & clr_i)) == $past(ev_i & stat_en_i & clr_i)));

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(status_o & sig_en_i)));
endmodule

// File: rtl/mem_watch_mon.sv
module mem_watch_mon
  import mwm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REGION-1:0]    acc_valid,
  input  logic [NUM_REGION-1:0]    acc_write,
  input  logic [NUM_REGION-1:0]    acc_unalloc,
  input  logic [NUM_REGION*AW-1:0] acc_addr,
  input  logic                     reg_wr,
  input  logic [SEL_W-1:0]         reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  output logic [NUM_FLAG-1:0]      status_o,
  output logic                     irq
);
  localparam int WW = AW - 3;

  logic [NUM_FLAG-1:0]      ev;
  logic [NUM_FLAG-1:0]      stat_en;
  logic [NUM_FLAG-1:0]      sig_en;
  logic [NUM_FLAG-1:0]      clr;
  logic [NUM_REGION*WW-1:0] unit;
  logic [NUM_REGION-1:0]    dir;

  for (genvar g = 0; g < NUM_REGION; g++) begin : g_region
    logic err_ev, hit_ev;

    mwm_watch_cmp #(.AW(AW)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_i   (acc_valid[g]),
      .write_i   (acc_write[g]),
      .unalloc_i (acc_unalloc[g]),
      .addr_i    (acc_addr[g*AW +: AW]),
      .unit_i    (unit[g*WW +: WW]),
      .dir_i     (dir[g]),
      .err_ev_o  (err_ev),
      .hit_ev_o  (hit_ev)
    );

    assign ev[err_pos(g)] = err_ev;
    assign ev[hit_pos(g)] = hit_ev;
  end

  mwm_cfg_regs #(.AW(AW), .DW(DW)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .status_i    (status_o),
    .stat_en_o   (stat_en),
    .sig_en_o    (sig_en),
    .unit_o      (unit),
    .dir_o       (dir),
    .clr_o       (clr),
    .reg_rdata_o (reg_rdata)
  );

  mwm_status_reg u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_i      (ev),
    .stat_en_i (stat_en),
    .sig_en_i  (sig_en),
    .clr_i     (clr),
    .status_o  (status_o),
    .irq_o     (irq)
  );

  // R2
  err_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o[NUM_REGION-1:0] & ~$past(status_o[NUM_REGION-1:0])) != '0) |->
      ($past(acc_valid & acc_unalloc) != '0));
endmodule

// File: tb/mem_watch_mon_tb.sv
module mem_watch_mon_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NR = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NR-1:0] acc_valid, acc_write, acc_unalloc;
  logic [NR*AW-1:0] acc_addr;
  logic          reg_wr;
  logic [2:0]    reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic [5:0]    status_o;
  logic          irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_watch_mon #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_unalloc(acc_unalloc), .acc_addr(acc_addr), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .status_o(status_o), .irq(irq)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  int n_chk = 0;
  int n_fail = 0;
  int n_push = 0;
  int n_done = 0;
  bit finished = 0;

  // monitor: pops expected items and compares with the design outputs
  initial begin
    forever begin
      item_t it;
      logic [31:0] got;
      wait (sb.size() > 0);
      #1;
      it = sb.pop_front();
      case (it.kind)
        0:       got = 32'(status_o);
        1:       got = 32'(irq);
        default: got = reg_rdata;
      endcase
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
      end
      n_done++;
    end
  end

  task automatic push(int kind, logic [31:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    n_push++;
    sb.push_back(it);
    wait (n_done == n_push);
  endtask

  task automatic exp_status(logic [5:0] e, string req);
    push(0, 32'(e), req);
  endtask

  task automatic exp_irq(logic e, string req);
    push(1, 32'(e), req);
  endtask

  task automatic exp_rd(logic [2:0] a, logic [31:0] e, string req);
    reg_addr = a;
    push(2, e, req);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic regw(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic acc(int r, logic [AW-1:0] a, bit w, bit ua);
    @(negedge clk);
    acc_valid = '0; acc_valid[r] = 1'b1;
    acc_addr[r*AW +: AW] = a; acc_write[r] = w; acc_unalloc[r] = ua;
    @(negedge clk);
    acc_valid = '0; acc_write = '0; acc_unalloc = '0;
  endtask

  task automatic acc_and_clear(int r, logic [AW-1:0] a, bit w, bit ua, logic [5:0] c);
    @(negedge clk);
    acc_valid = '0; acc_valid[r] = 1'b1;
    acc_addr[r*AW +: AW] = a; acc_write[r] = w; acc_unalloc[r] = ua;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'(c);
    @(negedge clk);
    acc_valid = '0; acc_write = '0; acc_unalloc = '0;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    acc_valid = '0; acc_write = '0; acc_unalloc = '0; acc_addr = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1: reset state
    exp_status(6'h00, "R1 status after reset");
    exp_irq(1'b0, "R1 irq after reset");
    for (int a = 0; a < 6; a++) exp_rd(3'(a), 32'h0, "R1 register readback after reset");

    // R8: register map and field widths
    regw(3'd1, 32'hFFFF_FFFF);
    exp_rd(3'd1, 32'h0000_003F, "R8 status-enable width");
    regw(3'd2, 32'hFFFF_FFFF);
    exp_rd(3'd2, 32'h0000_003F, "R8 signal-enable width");
    regw(3'd4, 32'hFFFF_FFFF);
    exp_rd(3'd4, 32'h0000_3FFF, "R8 watch word width");
    exp_rd(3'd3, 32'h0, "R8 other watch word untouched");
    regw(3'd2, 32'h0);

    // watch setup: region0 unit 0x123 read, region1 unit 0x040 write, region2 unit 0x1FFF read
    regw(3'd3, (32'h123 << 1) | 32'h0);
    regw(3'd4, (32'h040 << 1) | 32'h1);
    regw(3'd5, (32'h1FFF << 1) | 32'h0);
    exp_rd(3'd3, 32'h0000_0246, "R8 watch region0 readback");
    exp_rd(3'd4, 32'h0000_0081, "R8 watch region1 readback");
    exp_rd(3'd5, 32'h0000_3FFE, "R8 watch region2 readback");

    // R2: unallocated errors per region
    acc(0, 16'h0010, 1'b0, 1'b1);
    exp_status(6'h01, "R2 region0 error");
    exp_rd(3'd0, 32'h0000_0001, "R8 status readback");
    regw(3'd0, 32'h1);
    exp_status(6'h00, "R5 clear region0 error");
    acc(1, 16'h0010, 1'b1, 1'b1);
    exp_status(6'h02, "R2 region1 error");
    acc(2, 16'h0010, 1'b0, 1'b1);
    exp_status(6'h06, "R2 region2 error");
    regw(3'd0, 32'h2);
    exp_status(6'h04, "R5 partial clear keeps bit2");
    regw(3'd0, 32'h3F);
    exp_status(6'h00, "R5 clear all");

    // R3: watch matches
    acc(0, 16'h091D, 1'b0, 1'b0);
    exp_status(6'h08, "R3 region0 hit mid-unit");
    regw(3'd0, 32'h3F);
    acc(0, 16'h0918, 1'b0, 1'b0);
    acc(0, 16'h091F, 1'b0, 1'b0);
    exp_status(6'h08, "R3 region0 hit unit edges");
    regw(3'd0, 32'h3F);
    acc(0, 16'h0920, 1'b0, 1'b0);
    acc(0, 16'h0917, 1'b0, 1'b0);
    exp_status(6'h00, "R3 neighbouring units miss");
    acc(0, 16'h0918, 1'b1, 1'b0);
    exp_status(6'h00, "R3 opposite direction misses");
    acc(1, 16'h0204, 1'b1, 1'b0);
    exp_status(6'h10, "R3 region1 write hit");
    regw(3'd0, 32'h3F);
    acc(1, 16'h0204, 1'b0, 1'b0);
    exp_status(6'h00, "R3 region1 read misses");
    acc(0, 16'h0204, 1'b1, 1'b0);
    exp_status(6'h00, "R3 other region address misses");
    acc(2, 16'hFFFF, 1'b0, 1'b0);
    exp_status(6'h20, "R3 region2 top unit hit");
    regw(3'd0, 32'h3F);

    // R4: status-enable gating
    regw(3'd1, 32'h3E);
    acc(0, 16'h0010, 1'b0, 1'b1);
    exp_status(6'h00, "R4 disabled error not latched");
    regw(3'd1, 32'h37);
    acc(0, 16'h0918, 1'b0, 1'b0);
    exp_status(6'h00, "R4 disabled hit not latched");
    regw(3'd1, 32'h3F);

    // R9: sticky across enable removal
    acc(0, 16'h0010, 1'b0, 1'b1);
    regw(3'd1, 32'h0);
    tick();
    exp_status(6'h01, "R9 flag held after enable cleared");
    regw(3'd1, 32'h3F);

    // R7: interrupt path, status bit0 set
    exp_irq(1'b0, "R7 no irq with signal-enable zero");
    regw(3'd2, 32'h02);
    tick();
    exp_irq(1'b0, "R7 non-matching signal-enable");
    regw(3'd2, 32'h01);
    exp_irq(1'b0, "R7 irq one cycle after enable");
    tick();
    exp_irq(1'b1, "R7 irq asserted");
    regw(3'd0, 32'h01);
    exp_status(6'h00, "R5 clear under irq");
    exp_irq(1'b1, "R7 irq lags clear by one cycle");
    tick();
    exp_irq(1'b0, "R7 irq dropped");
    regw(3'd2, 32'h0);

    // R6: event wins over same-cycle clear
    acc(0, 16'h0010, 1'b0, 1'b1);
    acc_and_clear(0, 16'h0010, 1'b0, 1'b1, 6'h01);
    exp_status(6'h01, "R6 event beats clear");
    acc(0, 16'h0918, 1'b0, 1'b0);
    exp_status(6'h09, "R3 error plus hit");
    acc_and_clear(0, 16'h0010, 1'b0, 1'b1, 6'h09);
    exp_status(6'h01, "R6 only colliding bit survives");

    finished = 1;
    summary();
    $finish;
  end
endmodule